// File: doc/BRIEF.md
# Floating-Point Error Reporter and Freeze Controller

This block tracks whether a floating-point exception is pending. It drives an active-low error pin while one is pending. When the pipeline decodes the next non-control floating-point instruction, the block decides what happens to it. Exceptions are reported as event pulses, each with a mask flag. An unmasked event marks an error as pending. The error stays pending until an explicit exception-cleared pulse arrives.

The decision depends on two controls. One is an external active-low ignore input, which first passes through a synchronizer. The other is a native-error-mode bit.

- With native mode off and ignore deasserted, a pending error raises a freeze request. The freeze holds the pipeline until the error is cleared.
- With native mode off and ignore asserted, execution continues, but the error pin still shows the error.
- With native mode on, the ignore input has no effect. A pending error produces a one-cycle internal fault request instead of a freeze.

A register-driven copy of the ignore level resets to zero, and zero means asserted. Ignore counts as asserted when either the synchronized pin or this register is low.

Top module: `fpe_report_ctrl`

## Requirements
- R1: After reset, the error pin is high, freeze and fault are low, and the ignore register reads 0.
- R2: An exception event with the mask flag low drives the error pin low in the cycle after the event.
- R3: An exception event with the mask flag high leaves the error pin and the pending state unchanged.
- R4: The pending state holds until a clear pulse. The error pin returns high the cycle after the clear. When an unmasked event and a clear arrive in the same cycle, the error stays pending.
- R5: Freeze rises in the cycle after a non-control strobe sees all of these at once: an error pending, native mode off, and ignore deasserted. Freeze then holds until the cycle after a clear pulse.
- R6: While ignore is asserted (pin low) and native mode is off, a pending error causes no freeze, and the error pin stays low.
- R7: In native mode, a non-control strobe with an error pending gives a fault pulse one cycle long in the following cycle and no freeze, whatever the ignore level.
- R8: A strobe flagged as a control instruction never causes a freeze or a fault.
- R9: The ignore pin passes through two flops. A new pin level set before edge e first affects a strobe sampled at edge e+2.
- R10: Writing the ignore register shows the new value on its output in the next cycle. A register value of 0 asserts ignore whatever the pin level (1 = deasserted).
- R11: Without a pending error, a strobe causes neither freeze nor fault. Freeze and fault are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exc_event_i | input | 1 | Pulse: the FPU raised an exception |
| exc_masked_i | input | 1 | The exception in this cycle is masked |
| exc_clear_i | input | 1 | Pulse: the exception state was cleared |
| fp_strobe_i | input | 1 | Decode strobe for a floating-point instruction |
| fp_ctrl_i | input | 1 | The strobed instruction is a control instruction |
| ignore_n_i | input | 1 | Asynchronous ignore-error input, active low |
| native_mode_i | input | 1 | Native error mode enable |
| ign_reg_wr_i | input | 1 | Write strobe for the ignore register |
| ign_reg_wdata_i | input | 1 | Value written to the ignore register |
| ferr_n_o | output | 1 | Error pin, active low |
| freeze_o | output | 1 | Freeze request to the pipeline |
| fault_o | output | 1 | One-cycle internal exception request |
| ignore_reg_n_o | output | 1 | Current ignore register value |

## Verification
The bench targets the synchronizer latency. It moves the pin and strobes at one and two edges after the change. A design that skipped or added a stage would freeze one cycle early or late. It also drives an unmasked event in the same cycle as a clear: a design that gave the clear priority would drop an error that had just arrived. Control-instruction strobes and native mode with the pin both high and low are covered as well. A wrong design would stall on a status-saving instruction, or let the ignore input suppress the native fault. A long random stream mixing all inputs is compared against a bench model every cycle.

// File: rtl/fpe_pkg.sv
// Shared types for the floating-point error reporter.
package fpe_pkg;

    // Decoded view of a floating-point instruction strobe.
    typedef struct packed {
        logic valid;
        logic is_ctrl;
    } fp_dec_t;

    // What the block does with a strobed instruction.
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_FREEZE = 2'd1,
        ACT_FAULT  = 2'd2
    } fp_action_e;

endpackage

// File: rtl/fpe_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes: d_i is a slowly changing level. The reset value is chosen so that
// the output reads as "deasserted" until the input has been sampled.
module fpe_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] stage_q;

    // Shift the input through the chain of flops.
    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= d_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fpe_ignore_reg.sv
// Register-driven copy of the active-low ignore level. Resets to 0 (asserted).
// Assumes: a single-cycle write strobe from the control block.
module fpe_ignore_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic wdata_i,
    output logic reg_n_o
);
    logic reg_q;

    // Hold the last written value.
    always_ff @(posedge clk) begin
        if (!rst_n)    reg_q <= 1'b0;
        else if (wr_i) reg_q <= wdata_i;
    end

    assign reg_n_o = reg_q;

    assert_reg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !reg_q);
    assert_reg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(reg_q));
endmodule

// File: rtl/fpe_pending.sv
// Pending-error tracker. An unmasked exception sets the state, and only a clear
// pulse resets it. When both arrive together, the new exception wins.
// Assumes: event and clear are single-cycle pulses from the FPU.
module fpe_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic mask_i,
    input  logic clr_i,
    output logic pend_o
);
    logic pend_q;
    logic set_w;

    assign set_w = ev_i && !mask_i;

    // Set on an unmasked exception, clear on the clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_w) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;

    assert_pend_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !mask_i) |=> pend_q);
    assert_pend_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> $past(ev_i && !mask_i));
    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/fpe_action.sv
// Decides what a strobed floating-point instruction does when an error is pending:
// nothing, freeze (held until clear), or a one-cycle fault in native mode.
// Assumes: ignore_n_i is already synchronized, and pend_i is the registered pending state.
module fpe_action
    import fpe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  fp_dec_t dec_i,
    input  logic    pend_i,
    input  logic    clr_i,
    input  logic    native_i,
    input  logic    ignore_n_i,
    output logic    freeze_o,
    output logic    fault_o
);
    logic       freeze_q;
    logic       fault_q;
    logic       trig_w;
    fp_action_e act_w;

    // Choose the action for the instruction strobed in this cycle.
    always_comb begin
        trig_w = dec_i.valid && !dec_i.is_ctrl && pend_i;
        act_w  = ACT_NONE;
        if (trig_w && !freeze_q) begin
            if (native_i)        act_w = ACT_FAULT;
            else if (ignore_n_i) act_w = ACT_FREEZE;
        end
    end

    // Register the freeze level and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            fault_q  <= 1'b0;
        end else begin
            fault_q <= (act_w == ACT_FAULT);
            if (clr_i)                    freeze_q <= 1'b0;
            else if (act_w == ACT_FREEZE) freeze_q <= 1'b1;
        end
    end

    assign freeze_o = freeze_q;
    assign fault_o  = fault_q;

    assert_freeze_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.valid && !dec_i.is_ctrl && pend_i && !native_i && ignore_n_i && !clr_i)
        |=> freeze_q);
    assert_freeze_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !clr_i) |=> freeze_q);
    assert_native_no_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(freeze_q) |-> $past(!native_i && ignore_n_i));
    assert_ctrl_no_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i.valid && dec_i.is_ctrl) |=> !fault_q);
    assert_idle_no_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_i |=> !fault_q);
    assert_one_action_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_q && freeze_q));
endmodule

// File: rtl/fpe_report_ctrl.sv
// Top level of the floating-point error reporter. It synchronizes the ignore pin,
// combines it with the ignore register, tracks the pending error, drives the
// active-low error pin, and issues freeze or fault requests.
// Assumes: all inputs other than ignore_n_i are synchronous to clk.
module fpe_report_ctrl #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic exc_event_i,
    input  logic exc_masked_i,
    input  logic exc_clear_i,
    input  logic fp_strobe_i,
    input  logic fp_ctrl_i,
    input  logic ignore_n_i,
    input  logic native_mode_i,
    input  logic ign_reg_wr_i,
    input  logic ign_reg_wdata_i,
    output logic ferr_n_o,
    output logic freeze_o,
    output logic fault_o,
    output logic ignore_reg_n_o
);
    import fpe_pkg::*;

    logic    ign_sync_n;
    logic    ign_reg_n;
    logic    ign_eff_n;
    logic    pend;
    fp_dec_t dec;

    fpe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ignore_n_i),
        .q_o   (ign_sync_n)
    );

    fpe_ignore_reg u_ign_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (ign_reg_wr_i),
        .wdata_i (ign_reg_wdata_i),
        .reg_n_o (ign_reg_n)
    );

    // Ignore is asserted when either source is low.
    assign ign_eff_n = ign_sync_n & ign_reg_n;

    fpe_pending u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_i   (exc_event_i),
        .mask_i (exc_masked_i),
        .clr_i  (exc_clear_i),
        .pend_o (pend)
    );

    // Pack the decode strobe for the action logic.
    assign dec = '{valid: fp_strobe_i, is_ctrl: fp_ctrl_i};

    fpe_action u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_i      (dec),
        .pend_i     (pend),
        .clr_i      (exc_clear_i),
        .native_i   (native_mode_i),
        .ignore_n_i (ign_eff_n),
        .freeze_o   (freeze_o),
        .fault_o    (fault_o)
    );

    assign ferr_n_o       = ~pend;
    assign ignore_reg_n_o = ign_reg_n;

    assert_ferr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_clear_i && !(exc_event_i && !exc_masked_i)) |=> ferr_n_o);
endmodule

// File: tb/fpe_report_ctrl_tb_top.sv
module fpe_report_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev = 0, msk = 0, clr = 0, fp = 0, ctl = 0, pin = 1, nat = 0, wr = 0, wd = 0;
    logic ferr_n, frz, flt, regn;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench model state.
    bit m_p, m_frz, m_flt, m_s1, m_s2, m_reg;

    always #2 clk = ~clk;

    fpe_report_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exc_event_i(ev), .exc_masked_i(msk), .exc_clear_i(clr),
        .fp_strobe_i(fp), .fp_ctrl_i(ctl), .ignore_n_i(pin), .native_mode_i(nat),
        .ign_reg_wr_i(wr), .ign_reg_wdata_i(wd), .ferr_n_o(ferr_n), .freeze_o(frz),
        .fault_o(flt), .ignore_reg_n_o(regn)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected pending state, derived from R2, R3, R4.
    function automatic bit f_pend(bit p, bit e, bit m, bit c);
        if (e && !m) return 1'b1;
        if (c)       return 1'b0;
        return p;
    endfunction

    // Advance one cycle: drive at negedge, update the model at posedge, compare at negedge.
    task automatic cyc(input bit e, input bit m, input bit c, input bit f, input bit k,
                       input bit w, input bit d);
        bit ign_on, trig, nf, nfl;
        ev = e; msk = m; clr = c; fp = f; ctl = k; wr = w; wd = d;
        @(posedge clk);
        if (!rst_n) begin
            m_p = 0; m_frz = 0; m_flt = 0; m_s1 = 1; m_s2 = 1; m_reg = 0;
        end else begin
            ign_on = !(m_s2 && m_reg);
            trig = f && !k && m_p;
            nfl = trig && nat && !m_frz;
            nf = c ? 1'b0 : (m_frz || (trig && !nat && !ign_on));
            m_p = f_pend(m_p, e, m, c);
            m_s2 = m_s1; m_s1 = pin;
            if (w) m_reg = d;
            m_frz = nf; m_flt = nfl;
        end
        @(negedge clk);
        chk(ferr_n == !m_p, "R2 error pin", int'(ferr_n), int'(!m_p));
        chk(frz == m_frz, "R5 freeze", int'(frz), int'(m_frz));
        chk(flt == m_flt, "R7 fault", int'(flt), int'(m_flt));
        chk(regn == m_reg, "R10 ignore register", int'(regn), int'(m_reg));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        idle(3);
        // R1: reset state
        chk(ferr_n == 1 && frz == 0 && flt == 0 && regn == 0, "R1 reset outputs",
            int'({ferr_n, frz, flt, regn}), 4'b1000);
        rst_n = 1;
        // R10: write register to deasserted, then let the pin settle.
        cyc(0, 0, 0, 0, 0, 1, 1);
        chk(regn == 1, "R10 write visible", int'(regn), 1);
        idle(3);
        // R3: masked event is ignored.
        cyc(1, 1, 0, 0, 0, 0, 0);
        chk(ferr_n == 1, "R3 masked event", int'(ferr_n), 1);
        // R2: unmasked event.
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk(ferr_n == 0, "R2 unmasked event", int'(ferr_n), 0);
        // R8: control instruction never freezes.
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk(frz == 0 && flt == 0, "R8 control strobe", int'({frz, flt}), 0);
        // R5: non-control strobe freezes, and the freeze holds.
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 1, "R5 freeze set", int'(frz), 1);
        idle(4);
        chk(frz == 1, "R5 freeze held", int'(frz), 1);
        // R4: clear releases the pin and the freeze.
        cyc(0, 0, 1, 0, 0, 0, 0);
        chk(ferr_n == 1 && frz == 0, "R4 clear", int'({ferr_n, frz}), 2'b10);
        // R6: ignore asserted via the pin.
        pin = 0; idle(3);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 0 && ferr_n == 0, "R6 ignore continues", int'({frz, ferr_n}), 0);
        // R9: pin release reaches the decision only at the third edge.
        pin = 1;
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 0, "R9 edge one", int'(frz), 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 0, "R9 edge two", int'(frz), 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 1, "R9 edge three", int'(frz), 1);
        cyc(0, 0, 1, 0, 0, 0, 0);
        // R7: native mode faults regardless of the ignore level.
        nat = 1;
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(flt == 1 && frz == 0, "R7 native fault", int'({flt, frz}), 2'b10);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(flt == 0, "R7 fault one cycle", int'(flt), 0);
        pin = 0; idle(3);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(flt == 1 && frz == 0, "R7 ignore has no effect", int'({flt, frz}), 2'b10);
        cyc(0, 0, 1, 0, 0, 0, 0);
        nat = 0; pin = 1; idle(3);
        // R10: register value 0 asserts ignore even with the pin high.
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 0 && regn == 0, "R10 register asserts ignore", int'({frz, regn}), 0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        // R4: an event in the same cycle as a clear wins.
        cyc(1, 0, 1, 0, 0, 0, 0);
        chk(ferr_n == 0, "R4 event beats clear", int'(ferr_n), 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        // R11: no pending error means no action.
        cyc(0, 0, 0, 1, 0, 0, 0);
        chk(frz == 0 && flt == 0, "R11 idle strobe", int'({frz, flt}), 0);
        // Random phase, compared against the model every cycle.
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(19) == 0) pin = ~pin;
            if ($urandom_range(199) == 0) nat = ~nat;
            begin
                bit e = ($urandom_range(15) == 0);
                bit m = $urandom_range(1);
                bit c = ($urandom_range(23) == 0);
                bit f = ($urandom_range(2) == 0);
                bit k = ($urandom_range(3) == 0);
                bit w = ($urandom_range(99) == 0);
                bit d = ($urandom_range(3) != 0);
                cyc(e, m, c, f, k, w, d);
            end
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule